// File: doc/BRIEF.md
# Floating-Point Error Interrupt and Ignore Controller

This block sits between a processor's active-low floating-point error output, its active-low "ignore numeric error" input, and one request line of an interrupt controller. A falling edge on the error line sets a request latch that drives the interrupt request. The falling edge is caught by an asynchronous pulse catcher, so even a pulse much shorter than a clock period is not lost. The catcher is followed by a two-stage synchronizer. A no-wait instruction that raises the error and withdraws it at once still produces a request.

The exception handler touches a fixed I/O port at address 0x00F0, with either a read or a write. That single access clears the pending request and arms the ignore latch, which drives the ignore output low. The ignore latch is cleared asynchronously whenever the error line is high. The ignore output therefore drops back to inactive on its own when software clears the FPU error. If the handler clears the FPU error before it touches the port, the ignore output never turns on. The order of the two handler steps does not matter.

Top module: `fpu_err_irq_ctrl`

## Requirements
- R1: A synchronous reset (rst high at a clock edge) leaves irq_req low and ignore_n high.
- R2: A falling edge on fpu_err_n sets irq_req at the third rising clock edge after the fall. irq_req then stays high, even after fpu_err_n returns high, until a port access clears it.
- R3: A low pulse on fpu_err_n shorter than one clock period still sets irq_req, at the same third rising edge.
- R4: A port access clears irq_req at the clock edge where it is seen. A port access is the rising edge of (io_wr OR io_rd) with io_addr equal to 16'h00F0.
- R5: A port access made while fpu_err_n is low drives ignore_n low from that same edge. ignore_n only goes low after a port access.
- R6: ignore_n is high whenever fpu_err_n is high, without waiting for a clock.
- R7: A port access made while fpu_err_n is high leaves ignore_n high, and ignore_n stays high when a later error arrives.
- R8: When fpu_err_n returns high, ignore_n returns high with no further port access.
- R9: An access to any other address has no effect. A strobe held high acts only once, at its rising edge.
- R10: If a port access and a newly latched error event fall in the same cycle, irq_req is low after that edge and high after the next one.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| fpu_err_n | input | 1 | Floating-point error from the processor, active low, asynchronous |
| io_addr | input | 16 | I/O address |
| io_wr | input | 1 | I/O write strobe, active high |
| io_rd | input | 1 | I/O read strobe, active high |
| irq_req | output | 1 | Interrupt request to the interrupt controller, active high |
| ignore_n | output | 1 | Ignore-numeric-error to the processor, active low |

## Verification
The hardest case to reach from the ports is a collision: the port access must be seen in exactly the cycle where a fresh error event leaves the synchronizer. The bench reaches it by counting edges. It lowers the error line just after one rising edge and raises the access strobe just after the second edge that follows. It then checks that the request is low after the third edge and high again after the fourth. A sub-cycle error pulse is produced by raising the line a few nanoseconds after lowering it, between two clock edges.

// File: rtl/fpu_err_irq_pkg.sv
package fpu_err_irq_pkg;
    localparam int unsigned IO_ADDR_W   = 16;
    localparam logic [IO_ADDR_W-1:0] FPERR_PORT = 16'h00F0;
    localparam int unsigned SYNC_DEPTH  = 2;

    typedef struct packed {
        logic irq;
        logic pend;
    } req_state_t;
endpackage

// File: rtl/fpu_err_catch.sv
module fpu_err_catch #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic err_n,
    output logic evt
);
    typedef struct packed {
        logic [STAGES-1:0] sync;
        logic              last;
        logic              clr;
    } catch_t;

    catch_t c_d, c_q;
    logic   caught;

    // Falling edge of the error line sets the catcher; the clock domain clears it.
    always_ff @(negedge err_n or posedge c_q.clr) begin
        if (c_q.clr) caught <= 1'b0;
        else         caught <= 1'b1;
    end

    always_comb begin
        c_d      = c_q;
        c_d.sync = {c_q.sync[STAGES-2:0], caught};
        c_d.last = c_q.sync[STAGES-1];
        c_d.clr  = c_q.sync[STAGES-1];
        if (rst) begin
            c_d.sync = '0;
            c_d.last = 1'b0;
            c_d.clr  = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        c_q <= c_d;
    end

    assign evt = c_q.sync[STAGES-1] & ~c_q.last;
endmodule

// File: rtl/fpu_port_decode.sv
module fpu_port_decode #(
    parameter int unsigned ADDR_W = 16,
    parameter logic [ADDR_W-1:0] PORT = '0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr,
    input  logic              rd,
    output logic              hit
);
    logic stb, stb_d, stb_q;

    assign stb = wr | rd;

    always_comb begin
        stb_d = rst ? 1'b0 : stb;
    end

    always_ff @(posedge clk) begin
        stb_q <= stb_d;
    end

    assign hit = stb & ~stb_q & (addr == PORT);
endmodule

// File: rtl/fpu_ignore_latch.sv
module fpu_ignore_latch (
    input  logic clk,
    input  logic rst,
    input  logic err_n,
    input  logic arm,
    output logic active
);
    logic act_d, act_q;

    always_comb begin
        act_d = act_q;
        if (arm) act_d = 1'b1;
        if (rst) act_d = 1'b0;
    end

    // An inactive error line holds the latch clear at any time.
    always_ff @(posedge clk or posedge err_n) begin
        if (err_n) act_q <= 1'b0;
        else       act_q <= act_d;
    end

    assign active = act_q;
endmodule

// File: rtl/fpu_err_irq_ctrl.sv
module fpu_err_irq_ctrl
    import fpu_err_irq_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 fpu_err_n,
    input  logic [IO_ADDR_W-1:0] io_addr,
    input  logic                 io_wr,
    input  logic                 io_rd,
    output logic                 irq_req,
    output logic                 ignore_n
);
    logic       err_evt;
    logic       port_hit;
    logic       ign_active;
    req_state_t r_d, r_q;

    fpu_err_catch #(.STAGES(SYNC_DEPTH)) u_catch (
        .clk   (clk),
        .rst   (rst),
        .err_n (fpu_err_n),
        .evt   (err_evt)
    );

    fpu_port_decode #(.ADDR_W(IO_ADDR_W), .PORT(FPERR_PORT)) u_decode (
        .clk  (clk),
        .rst  (rst),
        .addr (io_addr),
        .wr   (io_wr),
        .rd   (io_rd),
        .hit  (port_hit)
    );

    fpu_ignore_latch u_ignore (
        .clk    (clk),
        .rst    (rst),
        .err_n  (fpu_err_n),
        .arm    (port_hit),
        .active (ign_active)
    );

    // Request latch: a clear wins a collision, the event is kept for one cycle.
    always_comb begin
        r_d = r_q;
        if (port_hit) begin
            r_d.irq  = 1'b0;
            r_d.pend = err_evt;
        end else begin
            r_d.irq  = r_q.irq | err_evt | r_q.pend;
            r_d.pend = 1'b0;
        end
        if (rst) r_d = '0;
    end

    always_ff @(posedge clk) begin
        r_q <= r_d;
    end

    assign irq_req  = r_q.irq;
    assign ignore_n = ~ign_active;
endmodule

// File: rtl/fpu_err_irq_chk.sv
module fpu_err_irq_chk (
    input logic        clk,
    input logic        rst,
    input logic        fpu_err_n,
    input logic [15:0] io_addr,
    input logic        io_wr,
    input logic        io_rd,
    input logic        irq_req,
    input logic        ignore_n
);
    logic strb_q = 1'b0;
    logic hit_q  = 1'b0;
    logic hit;

    assign hit = (io_wr | io_rd) & ~strb_q & (io_addr == 16'h00F0);

    always_ff @(posedge clk) begin
        strb_q <= rst ? 1'b0 : (io_wr | io_rd);
        hit_q  <= rst ? 1'b0 : hit;
    end

    assert_reset_state_R1: assert property (@(posedge clk)
        $past(rst) |-> (!irq_req && ignore_n));

    assert_req_sticky_R2: assert property (@(posedge clk) disable iff (rst)
        (irq_req && !hit) |=> irq_req);

    assert_access_clears_R4: assert property (@(posedge clk) disable iff (rst)
        hit |=> !irq_req);

    assert_ignore_needs_access_R5: assert property (@(posedge clk) disable iff (rst)
        $fell(ignore_n) |-> hit_q);

    assert_ignore_off_R6: assert property (@(posedge clk) disable iff (rst)
        fpu_err_n |-> ignore_n);

    assert_late_access_R7: assert property (@(posedge clk) disable iff (rst)
        (hit && fpu_err_n) |=> ignore_n);
endmodule

bind fpu_err_irq_ctrl fpu_err_irq_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .fpu_err_n (fpu_err_n),
    .io_addr   (io_addr),
    .io_wr     (io_wr),
    .io_rd     (io_rd),
    .irq_req   (irq_req),
    .ignore_n  (ignore_n)
);

// File: tb/tb_fpu_err_irq_ctrl.sv
module tb_fpu_err_irq_ctrl;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        fpu_err_n = 1'b1;
    logic [15:0] io_addr = 16'h0000;
    logic        io_wr = 1'b0;
    logic        io_rd = 1'b0;
    logic        irq_req;
    logic        ignore_n;

    int n_vec = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    typedef struct {
        logic  irq;
        logic  ign_n;
        string tag;
    } exp_t;

    exp_t sb[$];

    always #5 clk = ~clk;

    fpu_err_irq_ctrl dut (
        .clk       (clk),
        .rst       (rst),
        .fpu_err_n (fpu_err_n),
        .io_addr   (io_addr),
        .io_wr     (io_wr),
        .io_rd     (io_rd),
        .irq_req   (irq_req),
        .ignore_n  (ignore_n)
    );

    // Monitor: compares queued expectations at the falling edge.
    always @(negedge clk) begin
        while (sb.size() > 0) begin
            exp_t e;
            e = sb.pop_front();
            n_vec++;
            if (irq_req !== e.irq || ignore_n !== e.ign_n) begin
                n_bad++;
                $display("FAIL %s: irq_req=%b ignore_n=%b expected irq_req=%b ignore_n=%b",
                         e.tag, irq_req, ignore_n, e.irq, e.ign_n);
            end
        end
    end

    task automatic tick(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic expect_out(input logic irq, input logic ign_n, input string tag);
        exp_t e;
        e.irq = irq; e.ign_n = ign_n; e.tag = tag;
        sb.push_back(e);
        @(negedge clk);
        #1;
    endtask

    task automatic port_access(input logic [15:0] a, input bit use_rd);
        io_addr = a;
        if (use_rd) io_rd = 1'b1; else io_wr = 1'b1;
        tick(1);
    endtask

    task automatic release_strobes();
        io_wr = 1'b0;
        io_rd = 1'b0;
        tick(1);
    endtask

    initial begin
        tick(3);
        rst = 1'b0;
        expect_out(1'b0, 1'b1, "R1");

        // R2: long error, request at third edge
        tick(1);
        fpu_err_n = 1'b0;
        tick(2);
        expect_out(1'b0, 1'b1, "R2 early");
        tick(1);
        expect_out(1'b1, 1'b1, "R2");

        // R4 / R5: port write clears request, arms ignore
        port_access(16'h00F0, 1'b0);
        expect_out(1'b0, 1'b0, "R4 R5");
        release_strobes();
        expect_out(1'b0, 1'b0, "R5 held");

        // R8: error withdrawn, ignore released without software
        fpu_err_n = 1'b1;
        #2;
        expect_out(1'b0, 1'b1, "R8 R6");
        tick(6);

        // R7: error cleared before the port read
        fpu_err_n = 1'b0;
        tick(3);
        expect_out(1'b1, 1'b1, "R2 second");
        fpu_err_n = 1'b1;
        tick(6);
        port_access(16'h00F0, 1'b1);
        expect_out(1'b0, 1'b1, "R7 R6");
        release_strobes();
        fpu_err_n = 1'b0;
        tick(3);
        expect_out(1'b1, 1'b1, "R7 later");
        fpu_err_n = 1'b1;
        port_access(16'h00F0, 1'b0);
        release_strobes();
        tick(6);

        // R3: sub-cycle pulse
        fpu_err_n = 1'b0;
        #3;
        fpu_err_n = 1'b1;
        tick(2);
        expect_out(1'b0, 1'b1, "R3 early");
        tick(1);
        expect_out(1'b1, 1'b1, "R3");
        tick(2);
        expect_out(1'b1, 1'b1, "R2 sticky");
        port_access(16'h00F0, 1'b0);
        release_strobes();
        expect_out(1'b0, 1'b1, "R4 pulse");
        tick(6);

        // R9: wrong address, held strobe
        fpu_err_n = 1'b0;
        tick(3);
        port_access(16'h00F1, 1'b0);
        expect_out(1'b1, 1'b1, "R9 addr");
        release_strobes();
        port_access(16'h00F0, 1'b0);
        expect_out(1'b0, 1'b0, "R4 R5 again");
        fpu_err_n = 1'b1;
        tick(6);
        fpu_err_n = 1'b0;
        tick(3);
        expect_out(1'b1, 1'b1, "R9 held strobe");
        release_strobes();
        expect_out(1'b1, 1'b1, "R9 release");
        port_access(16'h00F0, 1'b0);
        release_strobes();
        fpu_err_n = 1'b1;
        tick(6);

        // R10: clear and new event in the same cycle
        fpu_err_n = 1'b0;
        tick(2);
        io_addr = 16'h00F0;
        io_wr   = 1'b1;
        tick(1);
        expect_out(1'b0, 1'b0, "R10 clear wins");
        io_wr = 1'b0;
        tick(1);
        expect_out(1'b1, 1'b0, "R10 relatch");

        // R1 again: reset mid-activity
        rst = 1'b1;
        tick(1);
        rst = 1'b0;
        expect_out(1'b0, 1'b1, "R1 reset");
        fpu_err_n = 1'b1;
        tick(4);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: run did not finish, actual=hung expected=done");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end
endmodule